// File: doc/BRIEF.md
# Runtime-Selectable Index Cache Lookup

This block is the lookup path of a direct-mapped cache whose line index is not a fixed field of the address. The block-offset bits are discarded first. A selection mask then picks exactly as many of the remaining address bits as the index needs. Each request is answered in the same cycle with a hit flag and the line index it used. On a miss, the line is refilled at the next clock edge: its tag is written and the line is marked valid.

Software can choose the selection mask to suit the access pattern of the workload. A good choice spreads hot addresses across lines that would otherwise collide. Three design choices keep every mask safe to use:
- Each line stores every non-offset address bit as its tag.
- A mask write is accepted only when it has exactly the right number of set bits.
- Accepting a new mask invalidates the whole cache.

The data array, write policy and backing memory are not part of this block.

The block has no sequencing state machine. A lookup, a fill and an invalidation each finish in a single edge. Its only modes are the mask currently held and the valid state of each line.

Top module: `bsel_cache_indexer`

## Requirements
- R1: After reset the mask selects the INDEX_W lowest non-offset bits and every line is invalid, so the first request misses.
- R2: The OFFSET_W lowest address bits never affect the index or the hit result. Two addresses that differ only there share a line.
- R3: rsp_index packs the address bits selected by the mask in ascending order. Mask bit k stands for address bit OFFSET_W+k. The lowest selected bit becomes index bit 0.
- R4: Under the default mask, rsp_index equals address bits OFFSET_W+INDEX_W-1 down to OFFSET_W.
- R5: A cfg_we pulse whose cfg_mask has exactly INDEX_W set bits is accepted. It governs every request from the next cycle onward.
- R6: A cfg_we pulse whose cfg_mask has any other number of set bits is ignored. The old mask stays in force and no line is invalidated.
- R7: An accepted mask write clears every valid bit at the same edge, so each following request misses until it is refilled.
- R8: rsp_hit is high only when the indexed line is valid and its stored tag equals all non-offset address bits. On a miss, that line takes the new tag and becomes valid at the next edge.
- R9: While req_valid is low, rsp_hit is low and no line is filled.
- R10: When a request coincides with an accepted mask write, it is looked up under the old mask. Its fill is dropped, because the invalidation takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_mask | input | ADDR_W-OFFSET_W | Proposed selection mask, one bit per non-offset address bit |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Lookup address |
| rsp_hit | output | 1 | Lookup hit, same cycle as the request |
| rsp_index | output | INDEX_W | Line index used by the lookup |

## Verification
The hardest cases to reach from the ports come from how the mask interacts with the stored lines. One is a tag mismatch between two addresses that land on the same line only under a non-default mask. Another is a mask write that lands in the same cycle as a request. Random addresses are drawn from a small pool so that lines are reused and collide often. Random mask writes, both legal and illegal, are scattered through the run and checked against a reference model. Directed sequences force the same-cycle write, the rejected write on a resident line, and a hand-picked three-bit selection.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
    // population count of a mask up to 32 bits wide
    function automatic int unsigned ones32(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) n += int'(v[i]);
        return n;
    endfunction
endpackage

// File: rtl/bsel_mask_reg.sv
module bsel_mask_reg #(
    parameter int Z = 10,
    parameter int M = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [Z-1:0] cfg_mask,
    output logic [Z-1:0] mask_o,
    output logic         accept_o
);
    import bsel_pkg::*;
    localparam logic [Z-1:0] DEF_MASK = Z'((64'd1 << M) - 64'd1);

    logic [Z-1:0] mask_q;

    always_comb accept_o = cfg_we && (ones32(32'(cfg_mask)) == M);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask_q <= DEF_MASK;
        else if (accept_o) mask_q <= cfg_mask;
    end

    assign mask_o = mask_q;

    // R6
    reject_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && $countones(cfg_mask) != M) |=> $stable(mask_q));
    // R5
    accept_loads_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && $countones(cfg_mask) == M) |=> (mask_q == $past(cfg_mask)));
endmodule

// File: rtl/bsel_index_pick.sv
module bsel_index_pick #(
    parameter int Z = 10,
    parameter int M = 3
) (
    input  logic [Z-1:0] key_i,
    input  logic [Z-1:0] mask_i,
    output logic [M-1:0] idx_o
);
    // walk from the top so the lowest selected bit ends at position 0
    always_comb begin
        idx_o = '0;
        for (int k = Z - 1; k >= 0; k--) begin
            if (mask_i[k]) idx_o = (idx_o << 1) | M'(key_i[k]);
        end
    end
endmodule

// File: rtl/bsel_tag_store.sv
module bsel_tag_store #(
    parameter int Z = 10,
    parameter int M = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         req_i,
    input  logic [M-1:0] idx_i,
    input  logic [Z-1:0] key_i,
    output logic         hit_o
);
    localparam int LINES = 1 << M;

    logic [LINES-1:0] valid_q;
    logic [Z-1:0]     tag_q [LINES];

    always_comb hit_o = req_i && valid_q[idx_i] && (tag_q[idx_i] == key_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush_i) begin
            valid_q <= '0;
        end else if (req_i && !hit_o) begin
            valid_q[idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!flush_i && req_i && !hit_o) tag_q[idx_i] <= key_i;
    end

    // R7
    flush_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0));
    // R9
    idle_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && !flush_i) |=> $stable(valid_q));
endmodule

// File: rtl/bsel_cache_indexer.sv
module bsel_cache_indexer #(
    parameter int ADDR_W   = 12,
    parameter int OFFSET_W = 2,
    parameter int INDEX_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [ADDR_W-OFFSET_W-1:0]   cfg_mask,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    output logic                         rsp_hit,
    output logic [INDEX_W-1:0]           rsp_index
);
    localparam int Z = ADDR_W - OFFSET_W;

    logic [Z-1:0] key;
    logic [Z-1:0] mask;
    logic         accept;

    assign key = req_addr[ADDR_W-1:OFFSET_W];

    bsel_mask_reg #(.Z(Z), .M(INDEX_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_mask (cfg_mask),
        .mask_o   (mask),
        .accept_o (accept)
    );

    bsel_index_pick #(.Z(Z), .M(INDEX_W)) u_pick (
        .key_i  (key),
        .mask_i (mask),
        .idx_o  (rsp_index)
    );

    bsel_tag_store #(.Z(Z), .M(INDEX_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (accept),
        .req_i   (req_valid),
        .idx_i   (rsp_index),
        .key_i   (key),
        .hit_o   (rsp_hit)
    );

    // R9
    no_hit_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !rsp_hit);
    // R7
    miss_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !rsp_hit);
    // R8
    refill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid && !rsp_hit && !accept && !cfg_we) && req_valid && !cfg_we
         && req_addr == $past(req_addr)) |-> rsp_hit);
    // R4
    default_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == Z'((64'd1 << INDEX_W) - 64'd1)) |-> (rsp_index == key[INDEX_W-1:0]));
endmodule

// File: tb/bsel_cache_indexer_tb_top.sv
module bsel_cache_indexer_tb_top;
    localparam int AW = 12;
    localparam int OW = 2;
    localparam int IW = 3;
    localparam int Z  = AW - OW;
    localparam int NL = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [Z-1:0]  cfg_mask;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          rsp_hit;
    logic [IW-1:0] rsp_index;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [Z-1:0] m_mask;
    logic [NL-1:0] m_valid;
    logic [Z-1:0] m_tag [NL];

    always #5 clk = ~clk;

    bsel_cache_indexer #(.ADDR_W(AW), .OFFSET_W(OW), .INDEX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_hit(rsp_hit), .rsp_index(rsp_index)
    );

    function automatic int popc(input logic [Z-1:0] v);
        int n = 0;
        for (int i = 0; i < Z; i++) if (v[i]) n++;
        return n;
    endfunction

    function automatic logic [IW-1:0] ref_index(input logic [Z-1:0] msk, input logic [AW-1:0] a);
        logic [IW-1:0] r = '0;
        int pos = 0;
        for (int k = 0; k < Z; k++) begin
            if (msk[k]) begin
                if (pos < IW) r[pos] = a[OW + k];
                pos++;
            end
        end
        return r;
    endfunction

    function automatic logic [Z-1:0] rand_good_mask();
        logic [Z-1:0] r = '0;
        while (popc(r) < IW) r[$urandom % Z] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, check combinational response, update model
    task automatic cyc(input logic we, input logic [Z-1:0] msk, input logic rv,
                       input logic [AW-1:0] a, input string req);
        logic [IW-1:0] ei;
        logic eh;
        cfg_we = we; cfg_mask = msk; req_valid = rv; req_addr = a;
        #2;
        ei = ref_index(m_mask, a);
        eh = rv && m_valid[ei] && (m_tag[ei] == a[AW-1:OW]);
        chk(req, 32'(rsp_hit), 32'(eh));
        if (rv) chk(req, 32'(rsp_index), 32'(ei));
        if (we && popc(msk) == IW) begin
            m_mask = msk;
            m_valid = '0;
        end else if (rv && !eh) begin
            m_valid[ei] = 1'b1;
            m_tag[ei] = a[AW-1:OW];
        end
        @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [AW-1:0] pool [16];
        logic [AW-1:0] a;
        logic [Z-1:0] mk;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; cfg_we = 0; cfg_mask = '0; req_valid = 0; req_addr = '0;
        m_mask = Z'((1 << IW) - 1);
        m_valid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, first request misses; R4 default indexing
        cyc(0, '0, 0, 12'h000, "R1");
        cyc(0, '0, 1, 12'h0A4, "R1");
        chk("R4", 32'(ref_index(m_mask, 12'h0A4)), 32'(3'b001));
        // R2: same line, different offset -> hit, same index
        cyc(0, '0, 1, 12'h0A7, "R2");
        chk("R2", 32'(rsp_index), 32'(3'b001));
        // R9: idle request to resident address -> no hit
        cyc(0, '0, 0, 12'h0A4, "R9");
        // R8: alias with differing upper bits evicts, then original misses
        cyc(0, '0, 1, 12'hFA4, "R8");
        cyc(0, '0, 1, 12'h0A4, "R8");
        cyc(0, '0, 1, 12'h0A4, "R8");
        // R6: rejected masks (four and zero set bits) keep lines and mask
        cyc(1, 10'b0000001111, 0, '0, "R6");
        cyc(1, 10'b0000000000, 0, '0, "R6");
        cyc(0, '0, 1, 12'h0A4, "R6");
        chk("R6", 32'(rsp_hit), 32'd1);
        // R10: coincident request uses old mask, fill dropped
        cyc(1, 10'b1000010010, 1, 12'h0A4, "R10");
        // R7: everything misses after the accepted write
        cyc(0, '0, 1, 12'h0A4, "R7");
        // R3/R5: bits 1,4,9 selected -> index {a[11],a[6],a[3]}
        cyc(0, '0, 1, 12'b100001001000, "R3");
        chk("R3", 32'(rsp_index), 32'(3'b111));
        cyc(0, '0, 1, 12'b000001000000, "R5");
        chk("R5", 32'(rsp_index), 32'(3'b010));

        for (int i = 0; i < 16; i++) pool[i] = AW'($urandom);
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom % 100;
            a = pool[$urandom % 16];
            a[OW-1:0] = OW'($urandom);
            if (sel < 2) begin
                mk = rand_good_mask();
                cyc(1, mk, ($urandom % 2) == 1, a, "R5");
            end else if (sel < 4) begin
                mk = Z'($urandom);
                cyc(1, mk, 1, a, "R6");
            end else if (sel < 10) begin
                cyc(0, '0, 0, a, "R9");
            end else begin
                cyc(0, '0, 1, a, "R8");
            end
        end
        report();
    end
endmodule